// File: doc/BRIEF.md
# Packed Bit Modify and Insert Unit

This unit is a single-stage execution slice for 128-bit vector registers. Each request operates on every lane of the vector at once. A 7-bit format/immediate field sets the lane width (8, 16, 32 or 64 bits) and also carries a bit index `m`. Three operations change one bit per lane of the source vector: force it low, force it high, or flip it. Two insert operations merge part of the source lane into the old destination lane. Insert-left takes the `m+1` top bits of the source. Insert-right takes the `m+1` bottom bits of the source.

Register-file reads and instruction decode are left to the surrounding pipeline. That pipeline supplies four inputs: the source vector, the current contents of the destination register, the format/immediate field taken from instruction bits 22:16, and the 3-bit operation code taken from instruction bits 25:23. The result appears one clock cycle later. It comes with a valid strobe and a flag for reserved encodings.

Top module: `bitmod_unit`

## Requirements
- R1: The format field selects the lane width by its leading bits. `0xxxxxx` selects 64-bit lanes with m = bits 5:0. `10xxxxx` selects 32-bit lanes with m = bits 4:0. `110xxxx` selects 16-bit lanes with m = bits 3:0. `1110xxx` selects 8-bit lanes with m = bits 2:0. `1111xxx` is a reserved format.
- R2: Operation code 3 (clear) returns each source lane with bit m forced to 0. All other bits pass through unchanged.
- R3: Operation code 4 (set) returns each source lane with bit m forced to 1. All other bits pass through unchanged.
- R4: Operation code 5 (invert) returns each source lane with bit m inverted. All other bits pass through unchanged.
- R5: Operation code 6 (insert-left) builds each lane from the m+1 most significant bits of the source lane and the remaining low bits of the destination lane.
- R6: Operation code 7 (insert-right) builds each lane from the m+1 least significant bits of the source lane and the remaining high bits of the destination lane.
- R7: When m+1 equals the lane width, insert-left and insert-right both return the source lane unchanged.
- R8: Lane i occupies bits [i*W +: W] of every vector. Each lane is computed only from its own bits, and no bit crosses a lane boundary.
- R9: A reserved format, or operation code 0, 1 or 2, sets the reserved flag. In that case the result is the old destination vector unchanged.
- R10: out_valid is high in the cycle after a cycle in which in_valid was sampled high, and low otherwise.
- R11: While in_valid is low, out_vec and out_rsvd keep their values.
- R12: After reset, out_valid, out_rsvd and out_vec are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (3 clear, 4 set, 5 invert, 6 insert-left, 7 insert-right) |
| fmt_imm | input | 7 | Lane width and bit index field |
| src_vec | input | VEC_W | Source vector |
| dst_vec | input | VEC_W | Current destination vector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | VEC_W | New destination vector |
| out_rsvd | output | 1 | Reserved format or operation code |

## Verification
Each lane width is driven with vectors whose lanes differ from each other, so a lane-placement or width-mux error produces a wrong lane. For the single-bit operations, m is set to zero, to the lane's top bit, and to a middle value; this separates a correct modulo from an index that is off by one or taken at the wrong width. The insert operations run on complementary source and destination patterns, so every result bit shows which operand it came from. The full-width case, m+1 equal to the lane width, is included because that is where the mask arithmetic wraps. Reserved formats and the unused operation codes are sent with a distinctive destination vector, so the passthrough of that vector can be seen directly.

// File: rtl/bitmod_pkg.sv
package bitmod_pkg;

   typedef enum logic [2:0] {
      OP_RSV0 = 3'd0,
      OP_RSV1 = 3'd1,
      OP_RSV2 = 3'd2,
      OP_CLR  = 3'd3,
      OP_SET  = 3'd4,
      OP_INV  = 3'd5,
      OP_INSL = 3'd6,
      OP_INSR = 3'd7
   } bm_op_e;

   // lane width code: width = 8 << code
   typedef enum logic [1:0] {
      LW_8  = 2'd0,
      LW_16 = 2'd1,
      LW_32 = 2'd2,
      LW_64 = 2'd3
   } bm_lw_e;

   localparam int unsigned NUM_LW    = 4;
   localparam int unsigned MAX_LANE  = 64;
   localparam int unsigned IDX_W     = 6;
   localparam int unsigned FMT_W     = 7;
   localparam int unsigned OP_W      = 3;

   function automatic int unsigned lane_bits(input int unsigned code);
      return 8 << code;
   endfunction

   function automatic logic op_is_legal(input logic [OP_W-1:0] op);
      return op >= OP_CLR;
   endfunction

endpackage

// File: rtl/bitmod_fmt_dec.sv
module bitmod_fmt_dec
   import bitmod_pkg::*;
(
   input  logic [FMT_W-1:0] fmt_imm,
   output bm_lw_e           lane_w,
   output logic [IDX_W-1:0] bit_idx,
   output logic             fmt_rsvd
);

   always_comb begin
      lane_w   = LW_64;
      bit_idx  = '0;
      fmt_rsvd = 1'b0;
      if (!fmt_imm[6]) begin
         lane_w  = LW_64;
         bit_idx = fmt_imm[5:0];
      end else if (!fmt_imm[5]) begin
         lane_w  = LW_32;
         bit_idx = {1'b0, fmt_imm[4:0]};
      end else if (!fmt_imm[4]) begin
         lane_w  = LW_16;
         bit_idx = {2'b00, fmt_imm[3:0]};
      end else if (!fmt_imm[3]) begin
         lane_w  = LW_8;
         bit_idx = {3'b000, fmt_imm[2:0]};
      end else begin
         fmt_rsvd = 1'b1;
      end
   end

   // decoded index must always fit inside the selected lane
   always_comb begin
      if (!fmt_rsvd) begin
         a_r1_idx_in_lane: assert (32'(bit_idx) < lane_bits(32'(lane_w)));
      end
   end

endmodule

// File: rtl/bitmod_lane.sv
module bitmod_lane
   import bitmod_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0]     src,
   input  logic [W-1:0]     dst,
   input  logic [IDX_W-1:0] idx,
   input  logic [OP_W-1:0]  op,
   output logic [W-1:0]     res
);

   localparam int unsigned PW = $clog2(W);
   localparam logic [W-1:0] ONES = {W{1'b1}};
   localparam logic [PW:0]  TOP  = (PW+1)'(W - 1);

   if (W < 8 || W > MAX_LANE || (W & (W - 1)) != 0) begin : g_bad_w
      $error("bitmod_lane: W must be a power of two in 8..64");
   end

   logic [PW-1:0] pos;
   logic [PW:0]   pos_x;
   logic [W-1:0]  one_hot;
   logic [W-1:0]  hi_mask;
   logic [W-1:0]  lo_mask;

   // modulo lane width: keep only the low bits of the index
   assign pos     = idx[PW-1:0];
   assign pos_x   = {1'b0, pos};
   assign one_hot = {{(W-1){1'b0}}, 1'b1} << pos;
   // top pos+1 bits set; shifting by W empties the operand
   assign hi_mask = ~(ONES >> (pos_x + 1'b1));
   // bottom pos+1 bits set
   assign lo_mask = ONES >> (TOP - pos_x);

   always_comb begin
      case (op)
         OP_CLR:  res = src & ~one_hot;
         OP_SET:  res = src | one_hot;
         OP_INV:  res = src ^ one_hot;
         OP_INSL: res = (src & hi_mask) | (dst & ~hi_mask);
         OP_INSR: res = (src & lo_mask) | (dst & ~lo_mask);
         default: res = dst;
      endcase
   end

   always_comb begin
      if (op == OP_CLR) begin
         a_r2_bit_low: assert (res[pos] == 1'b0);
      end
      if (op == OP_SET) begin
         a_r3_bit_high: assert (res[pos] == 1'b1);
      end
      if (op == OP_INV) begin
         a_r4_single_flip: assert ($countones(res ^ src) == 1);
      end
      if ((op == OP_INSL || op == OP_INSR) && pos_x == TOP) begin
         a_r7_full_copy: assert (res == src);
      end
   end

endmodule

// File: rtl/bitmod_unit.sv
module bitmod_unit
   import bitmod_pkg::*;
#(
   parameter int unsigned VEC_W = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [OP_W-1:0]     op_sel,
   input  logic [FMT_W-1:0]    fmt_imm,
   input  logic [VEC_W-1:0]    src_vec,
   input  logic [VEC_W-1:0]    dst_vec,
   output logic                out_valid,
   output logic [VEC_W-1:0]    out_vec,
   output logic                out_rsvd
);

   if (VEC_W == 0 || (VEC_W % MAX_LANE) != 0) begin : g_bad_vec
      $error("bitmod_unit: VEC_W must be a nonzero multiple of 64");
   end

   bm_lw_e           lane_w;
   logic [IDX_W-1:0] bit_idx;
   logic             fmt_rsvd;

   bitmod_fmt_dec u_dec (
      .fmt_imm  (fmt_imm),
      .lane_w   (lane_w),
      .bit_idx  (bit_idx),
      .fmt_rsvd (fmt_rsvd)
   );

   logic [VEC_W-1:0] res_by_w [NUM_LW];

   // one full set of lanes per supported width
   for (genvar g = 0; g < NUM_LW; g++) begin : g_width
      localparam int unsigned LW  = 8 << g;
      localparam int unsigned NLN = VEC_W / LW;
      for (genvar l = 0; l < NLN; l++) begin : g_lane
         bitmod_lane #(.W(LW)) u_lane (
            .src (src_vec[l*LW +: LW]),
            .dst (dst_vec[l*LW +: LW]),
            .idx (bit_idx),
            .op  (op_sel),
            .res (res_by_w[g][l*LW +: LW])
         );
      end
   end

   logic             rsvd_now;
   logic [VEC_W-1:0] next_vec;

   always_comb begin
      rsvd_now = fmt_rsvd | ~op_is_legal(op_sel);
      next_vec = rsvd_now ? dst_vec : res_by_w[lane_w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_rsvd  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_vec  <= next_vec;
            out_rsvd <= rsvd_now;
         end
      end
   end

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_vec) && $stable(out_rsvd)));
   a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel < OP_CLR) |=> (out_rsvd && out_vec == $past(dst_vec)));
   a_r1_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt_imm[6:3] == 4'hF) |=> (out_rsvd && out_vec == $past(dst_vec)));

endmodule

// File: tb/test_bitmod_unit.sv
module test_bitmod_unit;

   localparam int VW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    op_sel = '0;
   logic [6:0]    fmt_imm = '0;
   logic [VW-1:0] src_vec = '0;
   logic [VW-1:0] dst_vec = '0;
   logic          out_valid;
   logic [VW-1:0] out_vec;
   logic          out_rsvd;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   bitmod_unit #(.VEC_W(VW)) i_bitmod_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .fmt_imm(fmt_imm), .src_vec(src_vec), .dst_vec(dst_vec),
      .out_valid(out_valid), .out_vec(out_vec), .out_rsvd(out_rsvd));

   // reference built straight from the requirement text
   function automatic void model(input logic [2:0] op, input logic [6:0] f,
                                 input logic [VW-1:0] s, input logic [VW-1:0] d,
                                 output logic [VW-1:0] r, output logic rv);
      int w; int m;
      rv = 1'b0; w = 64; m = 0;
      if (f[6] == 1'b0) begin w = 64; m = int'(f[5:0]); end
      else if (f[5] == 1'b0) begin w = 32; m = int'(f[4:0]); end
      else if (f[4] == 1'b0) begin w = 16; m = int'(f[3:0]); end
      else if (f[3] == 1'b0) begin w = 8;  m = int'(f[2:0]); end
      else rv = 1'b1;
      if (op < 3) rv = 1'b1;
      r = d;
      if (rv) return;
      for (int ln = 0; ln < VW / w; ln++) begin
         for (int b = 0; b < w; b++) begin
            int k; logic sb; logic db;
            k = ln * w + b; sb = s[k]; db = d[k];
            case (op)
               3'd3: r[k] = (b == m) ? 1'b0 : sb;
               3'd4: r[k] = (b == m) ? 1'b1 : sb;
               3'd5: r[k] = (b == m) ? ~sb : sb;
               3'd6: r[k] = (b >= w - 1 - m) ? sb : db;
               default: r[k] = (b <= m) ? sb : db;
            endcase
         end
      end
   endfunction

   task automatic check(input string req, input logic [VW-1:0] got_v, input logic [VW-1:0] exp_v,
                        input logic got_f, input logic exp_f);
      total++;
      if (got_v !== exp_v || got_f !== exp_f) begin
         bad++;
         $display("FAIL %s: vec=%h rsvd=%b expected vec=%h rsvd=%b", req, got_v, got_f, exp_v, exp_f);
      end
   endtask

   task automatic run(input string req, input logic [2:0] op, input logic [6:0] f,
                      input logic [VW-1:0] s, input logic [VW-1:0] d);
      logic [VW-1:0] ev; logic ef;
      model(op, f, s, d, ev, ef);
      @(negedge clk);
      op_sel = op; fmt_imm = f; src_vec = s; dst_vec = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      total++;
      if (out_valid !== 1'b1) begin
         bad++;
         $display("FAIL R10: out_valid=%b expected 1", out_valid);
      end
      check(req, out_vec, ev, out_rsvd, ef);
   endtask

   localparam logic [VW-1:0] PAT_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   localparam logic [VW-1:0] PAT_B = 128'hA5A5_5A5A_F00F_0FF0_3C3C_C3C3_9669_6996;

   task automatic t_reset;
      check("R12", out_vec, '0, out_rsvd, 1'b0);
      total++;
      if (out_valid !== 1'b0) begin bad++; $display("FAIL R12: out_valid=%b expected 0", out_valid); end
   endtask

   task automatic t_decode;
      logic [VW-1:0] ev; logic ef;
      // 64-bit lanes, m=63: set top bit of each lane
      run("R1", 3'd4, 7'b0111111, '0, '1);
      check("R1 sets bit 63", out_vec, 128'h8000_0000_0000_0000_8000_0000_0000_0000, out_rsvd, 1'b0);
      run("R1", 3'd4, 7'b10_11111, '0, '0);
      run("R1", 3'd4, 7'b110_1111, '0, '0);
      run("R1", 3'd4, 7'b1110_101, '0, '0);
      check("R1 byte m=5", out_vec, {16{8'h20}}, out_rsvd, 1'b0);
      model(3'd4, 7'b1110_101, '0, '0, ev, ef);
   endtask

   task automatic t_single_bit;
      for (int g = 0; g < 4; g++) begin
         logic [6:0] fb;
         fb = (g == 0) ? 7'b0000000 : (g == 1) ? 7'b1000000 : (g == 2) ? 7'b1100000 : 7'b1110000;
         for (int mi = 0; mi < 3; mi++) begin
            logic [6:0] f; int top;
            top = (64 >> g) - 1;
            f = fb | 7'((mi == 0) ? 0 : (mi == 1) ? top : top / 2);
            run("R2", 3'd3, f, PAT_A, PAT_B);
            run("R3", 3'd4, f, PAT_A, PAT_B);
            run("R4", 3'd4 + 3'd1, f, PAT_B, PAT_A);
         end
      end
   endtask

   task automatic t_insert;
      run("R5", 3'd6, 7'b1110_010, PAT_A, ~PAT_A);
      run("R5", 3'd6, 7'b0_000000, PAT_B, ~PAT_B);
      run("R5", 3'd6, 7'b10_01100, '1, '0);
      check("R5 32-bit m=12", out_vec, {4{32'hFFF8_0000}}, out_rsvd, 1'b0);
      run("R6", 3'd7, 7'b110_0110, PAT_A, ~PAT_A);
      run("R6", 3'd7, 7'b0_100000, PAT_B, PAT_A);
      run("R6", 3'd7, 7'b1110_000, '1, '0);
      check("R6 byte m=0", out_vec, {16{8'h01}}, out_rsvd, 1'b0);
   endtask

   task automatic t_full;
      run("R7", 3'd6, 7'b1110_111, PAT_A, PAT_B);
      check("R7 insl byte full", out_vec, PAT_A, out_rsvd, 1'b0);
      run("R7", 3'd7, 7'b0_111111, PAT_B, PAT_A);
      check("R7 insr dword full", out_vec, PAT_B, out_rsvd, 1'b0);
      run("R7", 3'd7, 7'b10_11111, PAT_A, '0);
      run("R7", 3'd6, 7'b110_1111, PAT_B, '1);
   endtask

   task automatic t_lanes;
      // one lane only carries ones; neighbours must stay clear
      run("R8", 3'd5, 7'b110_0011, {112'h0, 16'hFFFF}, '0);
      check("R8 half lanes", out_vec, {{7{16'h0008}}, 16'hFFF7}, out_rsvd, 1'b0);
      run("R8", 3'd6, 7'b10_00011, {32'hFFFF_FFFF, 96'h0}, {96'h0, 32'hFFFF_FFFF});
   endtask

   task automatic t_reserved;
      run("R9", 3'd4, 7'b1111_010, PAT_A, PAT_B);
      check("R9 fmt passthru", out_vec, PAT_B, out_rsvd, 1'b1);
      for (int o = 0; o < 3; o++) begin
         run("R9", 3'(o), 7'b0_000101, PAT_B, PAT_A);
         check("R9 op passthru", out_vec, PAT_A, out_rsvd, 1'b1);
      end
   endtask

   task automatic t_hold;
      logic [VW-1:0] ev; logic ef;
      run("R11", 3'd5, 7'b0_000001, PAT_A, PAT_B);
      model(3'd5, 7'b0_000001, PAT_A, PAT_B, ev, ef);
      @(negedge clk);
      op_sel = 3'd0; fmt_imm = 7'h7F; src_vec = '0; dst_vec = '1;
      repeat (3) @(negedge clk);
      check("R11 hold", out_vec, ev, out_rsvd, ef);
      total++;
      if (out_valid !== 1'b0) begin bad++; $display("FAIL R10: out_valid=%b expected 0", out_valid); end
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_decode;
      t_single_bit;
      t_insert;
      t_full;
      t_lanes;
      t_reserved;
      t_hold;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule